// File: doc/BRIEF.md
# Add-Immediate ALU Slice with Status Flags

This block is one datapath slice of a processor core. It takes a small signed constant, sign-extends it, and adds it to one entry of a bank of data registers. The sum is written back into that same entry. In the same clock edge, a status word is updated with zero, negative, carry and signed-overflow indications for the new result. The carry and overflow indications each have a second mirror bit that always moves together with them. A sticky overflow bit records that some earlier add overflowed. It stays set until software rewrites the status word.

Operations arrive on a valid/ready port (`op_valid`, `op_ready`). The slice completes every operation in one cycle and never applies back-pressure, so `op_ready` is held high and an operation is taken on every clock edge where `op_valid` is high. Software sees the whole status word on `st_rd_data` and can replace it with `st_wr_en`/`st_wr_data`. A read port (`rd_sel`/`rd_data`) shows any data register. The data width defaults to 32 bits and is a parameter.

Top module: `addi_flag_unit`

## Requirements
- R1: An accepted operation writes `reg[op_reg] + sext(op_imm)` modulo 2^DATA_W into `reg[op_reg]` on the clock edge where it is taken. The immediate is 7 bits, -64..+63. No other register changes.
- R2: The zero flag (status bit 0) is set after an add exactly when the DATA_W-bit result is all zeros.
- R3: The negative flag (status bit 1) equals the most significant bit of the result after an add.
- R4: The carry flag (status bit 2) is the unsigned carry out of the top bit of the addition, with the immediate sign-extended to DATA_W bits.
- R5: The overflow flag (status bit 4) is set on two's-complement signed overflow and is recomputed on every add, so an add that does not overflow clears it.
- R6: The sticky overflow flag (status bit 6) is set by any add that overflows. Later adds that do not overflow leave it set.
- R7: After every add, the carry mirror (status bit 3) equals the carry flag, and the overflow mirror (status bit 5) equals the overflow flag.
- R8: A status write loads bits 6..0 from `st_wr_data`, including clearing the sticky flag. Bits 31..7 always read as zero.
- R9: If a status write and an add happen in the same cycle, the status word takes the written value, and the add still writes its sum to the register.
- R10: In a cycle with neither an add nor a status write, the registers and the status word keep their values.
- R11: Reset (active-low `rst_n`) clears every data register and every status flag.
- R12: `op_ready` is high whenever the block is out of reset, so every valid operation completes in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An add operation is presented this cycle |
| op_ready | output | 1 | Slice accepts an operation (held high) |
| op_reg | input | REG_AW | Index of the register that is both operand and destination |
| op_imm | input | 7 | Signed immediate added to the register |
| st_wr_en | input | 1 | Replace the status word this cycle |
| st_wr_data | input | 32 | New status word |
| st_rd_data | output | 32 | Current status word |
| rd_sel | input | REG_AW | Register shown on `rd_data` |
| rd_data | output | DATA_W | Contents of register `rd_sel` |

## Verification
The assertion that ties the zero and negative flags to the result assumes one thing about the inputs: `rd_sel` points at the register just written and holds that value for the following cycle. The property is checked only when the stimulus meets that condition. The assertions also assume that `op_reg` and `rd_sel` are always legal indices, which holds with a power-of-two register count. The bench keeps within these assumptions. It changes every input only on the falling clock edge and always points `rd_sel` at the register being operated on. It reaches the signed boundary within a few adds by building the slice with an 8-bit data width, which exercises the same carry and overflow paths as the 32-bit default.

// File: rtl/addi_pkg.sv
package addi_pkg;
  localparam int STAT_W = 32;
  localparam int IMM_W  = 7;

  localparam int BIT_Z  = 0;
  localparam int BIT_N  = 1;
  localparam int BIT_C  = 2;
  localparam int BIT_CM = 3;
  localparam int BIT_V  = 4;
  localparam int BIT_VM = 5;
  localparam int BIT_VS = 6;

  localparam int FLAG_N = 7;
  localparam logic [STAT_W-1:0] STAT_MASK = STAT_W'((1 << FLAG_N) - 1);

  // Field order matches the status bit positions, bit 0 last.
  typedef struct packed {
    logic vs;
    logic vm;
    logic v;
    logic cm;
    logic c;
    logic n;
    logic z;
  } stat_t;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } res_flags_t;
endpackage

// File: rtl/addi_adder.sv
module addi_adder
  import addi_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] sum,
  output res_flags_t        flags
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W:0]   wide;

  assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign wide    = {1'b0, opnd} + {1'b0, imm_ext};
  assign sum     = wide[DATA_W-1:0];

  always_comb begin
    flags.z = (sum == '0);
    flags.n = sum[DATA_W-1];
    flags.c = wide[DATA_W];
    flags.v = (opnd[DATA_W-1] == imm_ext[DATA_W-1]) &&
              (sum[DATA_W-1] != opnd[DATA_W-1]);
  end
endmodule

// File: rtl/addi_regfile.sv
module addi_regfile #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 8,
  localparam int REG_AW = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [REG_AW-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [REG_AW-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [NREGS-1:0][DATA_W-1:0] bank;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (we && (waddr == REG_AW'(g))) begin
        q <= wdata;
      end
    end
    assign bank[g] = q;
  end

  assign rdata_a = bank[raddr_a];
  assign rdata_b = bank[raddr_b];
endmodule

// File: rtl/addi_status.sv
module addi_status
  import addi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  res_flags_t        res,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] stat_word
);
  stat_t st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (wr_en) begin
      st_q <= stat_t'(wr_data[FLAG_N-1:0]);
    end else if (upd_en) begin
      st_q.z  <= res.z;
      st_q.n  <= res.n;
      st_q.c  <= res.c;
      st_q.cm <= res.c;
      st_q.v  <= res.v;
      st_q.vm <= res.v;
      st_q.vs <= st_q.vs | res.v;
    end
  end

  assign stat_word = {{(STAT_W-FLAG_N){1'b0}}, st_q};
endmodule

// File: rtl/addi_flag_unit.sv
module addi_flag_unit
  import addi_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREGS  = 8,
  localparam int REG_AW = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [REG_AW-1:0] op_reg,
  input  logic [IMM_W-1:0]  op_imm,
  input  logic              st_wr_en,
  input  logic [STAT_W-1:0] st_wr_data,
  output logic [STAT_W-1:0] st_rd_data,
  input  logic [REG_AW-1:0] rd_sel,
  output logic [DATA_W-1:0] rd_data
);
  logic              fire;
  logic [DATA_W-1:0] opnd;
  logic [DATA_W-1:0] sum;
  res_flags_t        res;

  assign op_ready = 1'b1;
  assign fire     = op_valid && op_ready;

  addi_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (fire),
    .waddr   (op_reg),
    .wdata   (sum),
    .raddr_a (op_reg),
    .rdata_a (opnd),
    .raddr_b (rd_sel),
    .rdata_b (rd_data)
  );

  addi_adder #(.DATA_W(DATA_W)) u_add (
    .opnd  (opnd),
    .imm   (op_imm),
    .sum   (sum),
    .flags (res)
  );

  addi_status u_st (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (fire),
    .res       (res),
    .wr_en     (st_wr_en),
    .wr_data   (st_wr_data),
    .stat_word (st_rd_data)
  );
endmodule

// File: rtl/addi_flag_unit_chk.sv
module addi_flag_unit_chk
  import addi_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [REG_AW-1:0] op_reg,
  input logic              st_wr_en,
  input logic [STAT_W-1:0] st_wr_data,
  input logic [STAT_W-1:0] st_rd_data,
  input logic [REG_AW-1:0] rd_sel,
  input logic [DATA_W-1:0] rd_data
);
  a_r2_r3_zero_neg: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !st_wr_en && rd_sel == op_reg) ##1 $stable(rd_sel) |->
      (st_rd_data[BIT_Z] == (rd_data == '0)) &&
      (st_rd_data[BIT_N] == rd_data[DATA_W-1]));

  a_r6_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !st_wr_en) |=> (!st_rd_data[BIT_V] || st_rd_data[BIT_VS]));

  a_r6_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_wr_en && st_rd_data[BIT_VS]) |=> st_rd_data[BIT_VS]);

  a_r7_mirrors: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !st_wr_en) |=>
      (st_rd_data[BIT_C] == st_rd_data[BIT_CM]) &&
      (st_rd_data[BIT_V] == st_rd_data[BIT_VM]));

  a_r8_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_en |=> st_rd_data == ($past(st_wr_data) & STAT_MASK));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !st_wr_en) |=> $stable(st_rd_data));
endmodule

bind addi_flag_unit addi_flag_unit_chk #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_reg     (op_reg),
  .st_wr_en   (st_wr_en),
  .st_wr_data (st_wr_data),
  .st_rd_data (st_rd_data),
  .rd_sel     (rd_sel),
  .rd_data    (rd_data)
);

// File: tb/addi_flag_unit_bench.sv
module addi_flag_unit_bench;
  localparam int W  = 8;
  localparam int NR = 8;
  localparam int AW = $clog2(NR);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic          op_ready;
  logic [AW-1:0] op_reg = '0;
  logic [6:0]    op_imm = '0;
  logic          st_wr_en = 1'b0;
  logic [31:0]   st_wr_data = '0;
  logic [31:0]   st_rd_data;
  logic [AW-1:0] rd_sel = '0;
  logic [W-1:0]  rd_data;

  always #5 clk = ~clk;

  addi_flag_unit #(.DATA_W(W), .NREGS(NR)) u_addi_flag_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_reg(op_reg), .op_imm(op_imm), .st_wr_en(st_wr_en),
    .st_wr_data(st_wr_data), .st_rd_data(st_rd_data), .rd_sel(rd_sel),
    .rd_data(rd_data)
  );

  typedef struct {
    string       tag;
    logic [31:0] st;
    logic [W-1:0] d;
  } item_t;

  item_t        sb[$];
  int           checks = 0;
  int           fails = 0;
  bit           done = 1'b0;
  logic [W-1:0] mregs [NR];
  logic [31:0]  mst = '0;

  // Status bits: Z0 N1 C2 Cmirror3 V4 Vmirror5 sticky6
  task automatic step(input bit v, input int r, input int imm, input bit we,
                      input logic [31:0] wd, input int sel, input string tag);
    logic [W:0]   wide;
    logic [W-1:0] a, b, s;
    logic         z, n, c, ov;
    item_t        it;
    @(negedge clk);
    op_valid   = v;
    op_reg     = AW'(r);
    op_imm     = imm[6:0];
    st_wr_en   = we;
    st_wr_data = wd;
    rd_sel     = AW'(sel);
    if (v) begin
      a    = mregs[r];
      b    = imm[W-1:0];
      wide = {1'b0, a} + {1'b0, b};
      s    = wide[W-1:0];
      z    = (s == '0);
      n    = s[W-1];
      c    = wide[W];
      ov   = (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
      mregs[r] = s;
      if (!we) mst = {25'b0, mst[6] | ov, ov, ov, c, c, n, z};
    end
    if (we) mst = wd & 32'h7F;
    it.tag = tag;
    it.st  = mst;
    it.d   = mregs[sel];
    sb.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        checks++;
        if (st_rd_data !== it.st) begin
          fails++;
          $display("FAIL %s status: actual %h expected %h", it.tag, st_rd_data, it.st);
        end
        checks++;
        if (rd_data !== it.d) begin
          fails++;
          $display("FAIL %s data: actual %h expected %h", it.tag, rd_data, it.d);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < NR; i++) mregs[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state of status and registers
    step(0, 0, 0, 0, 0, 0, "R11");
    step(0, 0, 0, 0, 0, 5, "R11");
    checks++;
    if (op_ready !== 1'b1) begin
      fails++;
      $display("FAIL R12 op_ready: actual %b expected 1", op_ready);
    end
    // R2 R4: around zero on reg 0
    step(1, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 1, 0, 0, 0, "R1");
    step(1, 0, -1, 0, 0, 0, "R4");
    step(1, 0, -1, 0, 0, 0, "R3");
    step(1, 0, 1, 0, 0, 0, "R4");
    // R3 R4: all-ones wrap on reg 1
    step(1, 1, -1, 0, 0, 1, "R3");
    step(1, 1, 1, 0, 0, 1, "R2");
    step(1, 1, 0, 0, 0, 1, "R4");
    step(1, 1, -64, 0, 0, 1, "R1");
    // R5 R6 R7: positive boundary on reg 2
    step(1, 2, 63, 0, 0, 2, "R1");
    step(1, 2, 63, 0, 0, 2, "R1");
    step(1, 2, 1, 0, 0, 2, "R1");
    step(1, 2, 1, 0, 0, 2, "R5");
    step(1, 2, -1, 0, 0, 2, "R7");
    step(1, 2, -1, 0, 0, 2, "R6");
    step(1, 2, 5, 0, 0, 2, "R6");
    // R8: writes clear sticky, reserved bits stay zero
    step(0, 0, 0, 1, 32'h0, 2, "R8");
    step(0, 0, 0, 1, 32'hFFFF_FFFF, 2, "R8");
    step(0, 0, 0, 1, 32'h0000_0055, 3, "R8");
    // R10: idle keeps state, other registers untouched by earlier adds
    step(0, 2, 10, 0, 0, 0, "R10");
    step(0, 2, 10, 0, 0, 3, "R10");
    // R5: negative boundary on reg 3, then recompute clears V
    step(1, 3, -64, 0, 0, 3, "R1");
    step(1, 3, -64, 0, 0, 3, "R1");
    step(1, 3, -1, 0, 0, 3, "R5");
    step(1, 3, 1, 0, 0, 3, "R5");
    step(1, 3, 1, 0, 0, 3, "R5");
    // R9: write and add in the same cycle
    step(1, 3, 7, 1, 32'h0000_0001, 3, "R9");
    step(1, 4, -3, 1, 32'h0000_0040, 4, "R9");
    step(0, 0, 0, 0, 0, 3, "R9");
    // R11: reset mid-run clears everything
    @(negedge clk);
    op_valid = 1'b0;
    st_wr_en = 1'b0;
    rst_n = 1'b0;
    for (int i = 0; i < NR; i++) mregs[i] = '0;
    mst = '0;
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 3, "R11");
    step(0, 0, 0, 0, 0, 2, "R11");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule